// File: doc/BRIEF.md
# Transmit Descriptor-Ring DMA Channel

This block moves outgoing data from memory to a byte-wide transmit stream without help from the processor. Software puts 8-byte descriptors in a ring in memory. Each descriptor holds a control word and then a buffer address. Software programs the ring's page and starts the engine. It hands over work by writing the ring offset just past the last valid descriptor. The engine reads descriptors and never writes them back. It fetches the buffer words through a single-request read port and emits the bytes with frame start and end markers. It raises a one-cycle interrupt for each descriptor that requests one.

The engine waits in an idle state once its current offset equals the posted offset. It wakes up by itself when software posts further. An end-of-table flag sends the engine back to the start of the ring. A malformed descriptor or a read error halts the engine and sets an error code. That code stays until software disables or flushes the channel. A suspend request lets an open frame complete and then keeps the engine from taking new work.

Top module: `tdma_tx_channel`

## Requirements
- R1: After reset, and while the enable bit is clear, the status word reads 0 in its low 20 bits: state disabled (0), no error, current offset 0. In this state tx_valid and mem_req stay low. The control register reads 0 after reset.
- R2: Registers are selected by reg_addr. Address 0 is control: bit 0 enable, bit 1 suspend, bit 2 loopback, bit 4 flush, and all other bits read 0. Address 1 is the ring base, which keeps bits [31:12] and reads 0 below them. Address 2 is the posted offset, which keeps bits [11:3] and reads 0 elsewhere. Address 3 is the status word, laid out as {active offset[31:20], error[19:16], state[15:12], current offset[11:0]}.
- R3: For the descriptor at offset c, the engine first reads the control word at base+c, then the address word at base+c+4. Every memory address it issues is word aligned. Descriptor control bits [27:20] have no effect.
- R4: Descriptor control word bits are: [12:0] byte count, 28 end-of-table, 29 interrupt, 30 end-of-frame, 31 start-of-frame. The engine emits exactly count bytes, starting at the buffer address, in ascending order. Byte k of a memory word sits at bits [8k+7:8k]. tx_sof marks the first byte of a start-of-frame descriptor and tx_eof marks the last byte of an end-of-frame descriptor. After the final descriptor of a batch completes, the active field holds that descriptor's offset.
- R5: A byte offered on tx_valid stays unchanged, together with its markers, until tx_ready accepts it.
- R6: When the current offset equals the posted offset, the state reads idle-wait (2) and nothing is fetched. Writing a different posted offset resumes the engine without any other action.
- R7: After a descriptor completes, the current offset advances by 8. If that descriptor has end-of-table set, the offset returns to 0 instead.
- R8: irq is high for exactly one cycle, the cycle after the last byte of a descriptor with the interrupt bit has been accepted. Descriptors without the bit produce no pulse.
- R9: A descriptor with start-of-frame clear while no frame is open, or with a byte count of 0, is a protocol error. It emits no bytes and sets error 1 and state stopped (3). The engine stays stopped until it is disabled or flushed.
- R10: A read error on a descriptor word sets error 4. A read error on a buffer word sets error 3. Both set state stopped (3).
- R11: While suspend is set and a frame is open, the state reads suspend-pending (4) and the frame continues to its end. Once the frame has closed, the engine stays in idle-wait (2) and fetches nothing, even if work is posted. Clearing suspend resumes the engine.
- R12: While flush is set, the engine drops the descriptor and frame in progress. tx_valid falls, and the status reads disabled with offset 0 and no error.
- R13: The loopback output follows control bit 2.
- R14: A memory request holds mem_req high with a stable mem_addr until mem_rvalid answers it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mem_req | output | 1 | Memory read request, held until answered |
| mem_addr | output | 32 | Word-aligned read address |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response data |
| mem_rerr | input | 1 | Read response carries a bus error |
| tx_valid | output | 1 | Output byte valid |
| tx_data | output | 8 | Output byte |
| tx_sof | output | 1 | First byte of a frame |
| tx_eof | output | 1 | Last byte of a frame |
| tx_ready | input | 1 | Sink accepts the byte |
| irq | output | 1 | Completion pulse |
| loopback | output | 1 | Loopback mode flag |

## Verification
The byte stream is checked against a bench model in several settings. Directed descriptors use unaligned buffers and a frame that spans descriptors, which separates lane order and marker placement from plain word copying. Random batches vary frame lengths, interrupt flags, sink stalls and memory latency, which exposes handshake and fetch-ordering faults that fixed timing hides. Separate directed cases cover the posted-offset boundary, the wrap, each error source, suspend with a frame open or closed, and flush, so each control path is exercised on its own.

// File: rtl/tdma_pkg.sv
package tdma_pkg;
    localparam int ADDR_W         = 32;
    localparam int DATA_W         = 32;
    localparam int PAGE_W         = 12;
    localparam int CNT_W          = 13;
    localparam int BYTES_PER_WORD = DATA_W / 8;
    localparam int LANE_W         = $clog2(BYTES_PER_WORD);
    localparam int DESC_BYTES     = 8;
    localparam int DESC_SH        = $clog2(DESC_BYTES);
    localparam int BASE_W         = ADDR_W - PAGE_W;

    localparam logic [1:0] RA_CTRL = 2'd0;
    localparam logic [1:0] RA_BASE = 2'd1;
    localparam logic [1:0] RA_POST = 2'd2;
    localparam logic [1:0] RA_STAT = 2'd3;

    typedef enum logic [3:0] {
        CS_DISABLED = 4'd0,
        CS_ACTIVE   = 4'd1,
        CS_IDLE     = 4'd2,
        CS_STOPPED  = 4'd3,
        CS_SUSPEND  = 4'd4
    } chan_state_e;

    typedef enum logic [3:0] {
        CE_NONE   = 4'd0,
        CE_PROTO  = 4'd1,
        CE_UNDER  = 4'd2,
        CE_BUFRD  = 4'd3,
        CE_DESCRD = 4'd4
    } chan_err_e;

    typedef enum logic [2:0] {
        E_OFF, E_IDLE, E_DCTL, E_DADR, E_BUF, E_SEND, E_DONE, E_STOP
    } eng_state_e;

    typedef struct packed {
        logic             sof;
        logic             eof;
        logic             ioc;
        logic             eot;
        logic [CNT_W-1:0] cnt;
    } desc_ctl_t;

    typedef struct packed {
        logic              en;
        logic              susp;
        logic              loop;
        logic              flush;
        logic [BASE_W-1:0] base;
        logic [PAGE_W-1:0] post;
    } chan_cfg_t;

    // flags ordered {sof, eof, ioc, eot} as found in control word bits 31..28
    function automatic desc_ctl_t decode_ctl(input logic [3:0] flags,
                                             input logic [CNT_W-1:0] cnt);
        desc_ctl_t d;
        d.sof = flags[3];
        d.eof = flags[2];
        d.ioc = flags[1];
        d.eot = flags[0];
        d.cnt = cnt;
        return d;
    endfunction

    function automatic logic [DATA_W-1:0] pack_status(input logic [PAGE_W-1:0] act,
                                                      input chan_err_e err,
                                                      input chan_state_e st,
                                                      input logic [PAGE_W-1:0] cur);
        return {act, err, st, cur};
    endfunction
endpackage

// File: rtl/tdma_regs.sv
module tdma_regs
    import tdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] status,
    output chan_cfg_t         cfg,
    output logic [DATA_W-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (we) begin
            case (addr)
                RA_CTRL: begin
                    cfg.en    <= wdata[0];
                    cfg.susp  <= wdata[1];
                    cfg.loop  <= wdata[2];
                    cfg.flush <= wdata[4];
                end
                RA_BASE: cfg.base <= wdata[ADDR_W-1:PAGE_W];
                RA_POST: cfg.post <= {wdata[PAGE_W-1:DESC_SH], {DESC_SH{1'b0}}};
                default: ;
            endcase
        end
    end

    always_comb begin
        case (addr)
            RA_CTRL: rdata = {{(DATA_W-5){1'b0}}, cfg.flush, 1'b0, cfg.loop, cfg.susp, cfg.en};
            RA_BASE: rdata = {cfg.base, {PAGE_W{1'b0}}};
            RA_POST: rdata = {{(DATA_W-PAGE_W){1'b0}}, cfg.post};
            default: rdata = status;
        endcase
    end
endmodule

// File: rtl/tdma_lane_pick.sv
module tdma_lane_pick
    import tdma_pkg::*;
(
    input  logic [DATA_W-1:0] word,
    input  logic [LANE_W-1:0] lane,
    output logic [7:0]        byte_o
);
    logic [7:0] lanes [BYTES_PER_WORD];

    for (genvar g = 0; g < BYTES_PER_WORD; g++) begin : g_lane
        assign lanes[g] = word[8*g +: 8];
    end

    assign byte_o = lanes[lane];
endmodule

// File: rtl/tdma_engine.sv
module tdma_engine
    import tdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  chan_cfg_t         cfg,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_rerr,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_sof,
    output logic              tx_eof,
    input  logic              tx_ready,
    output logic              irq,
    output logic [DATA_W-1:0] status
);
    eng_state_e          st;
    logic [PAGE_W-1:0]   cur, act;
    chan_err_e           err;
    logic                open_q;
    desc_ctl_t           dc;
    logic [ADDR_W-3:0]   waddr;
    logic [LANE_W-1:0]   lane;
    logic [CNT_W-1:0]    rem;
    logic                first;
    logic [DATA_W-1:0]   word;

    logic                hold;
    desc_ctl_t           fetched;
    logic                bad_desc;
    logic                last_byte;
    chan_state_e         vis_state;

    assign hold      = !cfg.en || cfg.flush;
    assign fetched   = decode_ctl(mem_rdata[31:28], mem_rdata[CNT_W-1:0]);
    assign bad_desc  = (!fetched.sof && !open_q) || (fetched.cnt == '0);
    assign last_byte = (rem == CNT_W'(1));

    always_comb begin
        mem_req  = 1'b0;
        mem_addr = '0;
        if (!hold) begin
            case (st)
                E_DCTL: begin mem_req = 1'b1; mem_addr = {cfg.base, cur}; end
                E_DADR: begin mem_req = 1'b1; mem_addr = {cfg.base, cur + PAGE_W'(4)}; end
                E_BUF:  begin mem_req = 1'b1; mem_addr = {waddr, 2'b00}; end
                default: ;
            endcase
        end
    end

    tdma_lane_pick u_pick (.word(word), .lane(lane), .byte_o(tx_data));

    assign tx_valid = (st == E_SEND) && !hold;
    assign tx_sof   = tx_valid && first;
    assign tx_eof   = tx_valid && last_byte && dc.eof;
    assign irq      = (st == E_DONE) && !hold && dc.ioc;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= E_OFF;
            cur    <= '0;
            act    <= '0;
            err    <= CE_NONE;
            open_q <= 1'b0;
            dc     <= '0;
            waddr  <= '0;
            lane   <= '0;
            rem    <= '0;
            first  <= 1'b0;
            word   <= '0;
        end else if (hold) begin
            st     <= E_OFF;
            cur    <= '0;
            err    <= CE_NONE;
            open_q <= 1'b0;
        end else begin
            case (st)
                E_OFF: st <= E_IDLE;
                E_IDLE: begin
                    if (!(cfg.susp && !open_q) && (cur != cfg.post))
                        st <= E_DCTL;
                end
                E_DCTL: begin
                    if (mem_rvalid) begin
                        if (mem_rerr) begin
                            err <= CE_DESCRD;
                            st  <= E_STOP;
                        end else if (bad_desc) begin
                            err <= CE_PROTO;
                            st  <= E_STOP;
                        end else begin
                            dc <= fetched;
                            st <= E_DADR;
                        end
                    end
                end
                E_DADR: begin
                    if (mem_rvalid) begin
                        if (mem_rerr) begin
                            err <= CE_DESCRD;
                            st  <= E_STOP;
                        end else begin
                            waddr  <= mem_rdata[ADDR_W-1:2];
                            lane   <= mem_rdata[LANE_W-1:0];
                            rem    <= dc.cnt;
                            first  <= dc.sof;
                            open_q <= 1'b1;
                            act    <= cur;
                            st     <= E_BUF;
                        end
                    end
                end
                E_BUF: begin
                    if (mem_rvalid) begin
                        if (mem_rerr) begin
                            err <= CE_BUFRD;
                            st  <= E_STOP;
                        end else begin
                            word <= mem_rdata;
                            st   <= E_SEND;
                        end
                    end
                end
                E_SEND: begin
                    if (tx_ready) begin
                        first <= 1'b0;
                        rem   <= rem - CNT_W'(1);
                        lane  <= lane + LANE_W'(1);
                        if (last_byte) begin
                            st <= E_DONE;
                        end else if (lane == {LANE_W{1'b1}}) begin
                            waddr <= waddr + 1'b1;
                            st    <= E_BUF;
                        end
                    end
                end
                E_DONE: begin
                    cur <= dc.eot ? '0 : cur + PAGE_W'(DESC_BYTES);
                    if (dc.eof)
                        open_q <= 1'b0;
                    st <= E_IDLE;
                end
                default: st <= E_STOP;
            endcase
        end
    end

    always_comb begin
        case (st)
            E_OFF:   vis_state = CS_DISABLED;
            E_STOP:  vis_state = CS_STOPPED;
            default: begin
                if (cfg.susp && open_q)
                    vis_state = CS_SUSPEND;
                else if (st == E_IDLE)
                    vis_state = CS_IDLE;
                else
                    vis_state = CS_ACTIVE;
            end
        endcase
    end

    assign status = pack_status(act, err, vis_state, cur);
endmodule

// File: rtl/tdma_tx_channel.sv
module tdma_tx_channel
    import tdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_rerr,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_sof,
    output logic              tx_eof,
    input  logic              tx_ready,
    output logic              irq,
    output logic              loopback
);
    chan_cfg_t         cfg;
    logic [DATA_W-1:0] status;

    tdma_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (reg_we),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .status (status),
        .cfg    (cfg),
        .rdata  (reg_rdata)
    );

    tdma_engine u_eng (
        .clk        (clk),
        .rst        (rst),
        .cfg        (cfg),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .mem_rerr   (mem_rerr),
        .tx_valid   (tx_valid),
        .tx_data    (tx_data),
        .tx_sof     (tx_sof),
        .tx_eof     (tx_eof),
        .tx_ready   (tx_ready),
        .irq        (irq),
        .status     (status)
    );

    assign loopback = cfg.loop;
endmodule

// File: rtl/tdma_checker.sv
module tdma_checker
    import tdma_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reg_we,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rvalid,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [7:0]        tx_data,
    input logic              tx_sof,
    input logic              tx_eof,
    input logic              irq,
    input logic [DATA_W-1:0] status
);
    assert_quiet_off_R1: assert property (@(posedge clk) disable iff (rst)
        (status[15:12] == 4'd0) |-> (!tx_valid && !mem_req));

    assert_word_aligned_R3: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    assert_marker_valid_R4: assert property (@(posedge clk) disable iff (rst)
        (tx_sof || tx_eof) |-> tx_valid);

    assert_byte_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready && !reg_we) |=>
            (tx_valid && $stable(tx_data) && $stable(tx_sof) && $stable(tx_eof)));

    assert_irq_single_R8: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    assert_stop_has_err_R9: assert property (@(posedge clk) disable iff (rst)
        (status[15:12] == 4'd3) |-> (status[19:16] != 4'd0));

    assert_req_hold_R14: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_rvalid && !reg_we) |=> (mem_req && $stable(mem_addr)));
endmodule

bind tdma_tx_channel tdma_checker i_tdma_checker (
    .clk        (clk),
    .rst        (rst),
    .reg_we     (reg_we),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_data    (tx_data),
    .tx_sof     (tx_sof),
    .tx_eof     (tx_eof),
    .irq        (irq),
    .status     (status)
);

// File: tb/test_tdma_tx_channel.sv
module test_tdma_tx_channel;
    localparam logic [31:0] F_SOF = 32'h8000_0000;
    localparam logic [31:0] F_EOF = 32'h4000_0000;
    localparam logic [31:0] F_IOC = 32'h2000_0000;
    localparam logic [31:0] F_EOT = 32'h1000_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = 32'd0;
    logic        mem_rerr = 1'b0;
    logic        tx_valid, tx_sof, tx_eof, irq, loopback;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b0;

    always #10 clk = ~clk;

    tdma_tx_channel i_tdma_tx_channel (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .mem_rerr(mem_rerr), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_sof(tx_sof), .tx_eof(tx_eof), .tx_ready(tx_ready), .irq(irq),
        .loopback(loopback)
    );

    int total = 0;
    int bad = 0;
    int irq_seen = 0;
    int irq_exp = 0;
    int bytes_seen = 0;
    int rdy_pct = 70;
    int lat_max = 2;
    int lat_cnt = 0;
    bit finished = 0;
    logic [31:0] mem [0:2047];
    logic [9:0]  exp_q [$];

    task automatic check(input bit ok, input string tag, input logic [31:0] got,
                         input logic [31:0] want);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, want);
        end
    endtask

    function automatic logic [7:0] mbyte(input int a);
        return mem[a >> 2][8*(a % 4) +: 8];
    endfunction

    // memory model, sink and stream monitor
    always @(negedge clk) begin
        tx_ready = ($urandom_range(99) < rdy_pct);
        if (mem_req) begin
            if (lat_cnt == 0) begin
                mem_rvalid = 1'b1;
                mem_rerr   = (mem_addr >= 32'h2000);
                mem_rdata  = (mem_addr < 32'h2000) ? mem[mem_addr[12:2]] : 32'hdead_beef;
                lat_cnt    = $urandom_range(lat_max);
            end else begin
                mem_rvalid = 1'b0;
                lat_cnt--;
            end
        end else begin
            mem_rvalid = 1'b0;
            mem_rerr   = 1'b0;
        end
        #2;
        if (irq) irq_seen++;
        if (tx_valid && tx_ready) begin
            logic [9:0] e;
            bytes_seen++;
            if (exp_q.size() == 0) begin
                check(0, "R4 unexpected byte", {22'd0, tx_sof, tx_eof, tx_data}, 32'd0);
            end else begin
                e = exp_q.pop_front();
                check(e == {tx_sof, tx_eof, tx_data}, "R4 byte/markers",
                      {22'd0, tx_sof, tx_eof, tx_data}, {22'd0, e});
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic put_desc(input int off, input logic [31:0] c, input logic [31:0] a);
        mem[off >> 2]       = c;
        mem[(off >> 2) + 1] = a;
    endtask

    task automatic expect_desc(input logic [31:0] c, input logic [31:0] a);
        int n;
        n = c[12:0];
        for (int i = 0; i < n; i++)
            exp_q.push_back({c[31] && (i == 0), c[30] && (i == n - 1), mbyte(int'(a) + i)});
        if (c[29]) irq_exp++;
    endtask

    task automatic wait_idle(input logic [11:0] target, input string tag);
        logic [31:0] s;
        for (int i = 0; i < 8000; i++) begin
            rd(2'd3, s);
            if (s[15:12] == 4'd2 && s[11:0] == target && exp_q.size() == 0) break;
        end
        check(s[15:12] == 4'd2, {tag, " R6 idle state"}, s, 32'h2000);
        check(s[11:0] == target, {tag, " R7 current offset"}, {20'd0, s[11:0]}, {20'd0, target});
        check(s[19:16] == 4'd0, {tag, " R4 no error"}, {28'd0, s[19:16]}, 32'd0);
        check(exp_q.size() == 0, {tag, " R4 all bytes out"}, exp_q.size(), 32'd0);
        check(irq_seen == irq_exp, {tag, " R8 irq count"}, irq_seen, irq_exp);
    endtask

    task automatic wait_state(input logic [3:0] want, output logic [31:0] s);
        for (int i = 0; i < 3000; i++) begin
            rd(2'd3, s);
            if (s[15:12] == want) break;
        end
    endtask

    task automatic stop_case(input logic [31:0] c, input logic [31:0] a,
                             input logic [3:0] code, input string tag);
        logic [31:0] s;
        int b0;
        b0 = bytes_seen;
        put_desc(0, c, a);
        wr(2'd0, 32'h1);
        wait_state(4'd3, s);
        check(s[15:12] == 4'd3, {tag, " stopped state"}, {28'd0, s[15:12]}, 32'd3);
        check(s[19:16] == code, {tag, " error code"}, {28'd0, s[19:16]}, {28'd0, code});
        check(bytes_seen == b0, {tag, " R9 no bytes"}, bytes_seen, b0);
        repeat (20) @(negedge clk);
        rd(2'd3, s);
        check(s[15:12] == 4'd3, {tag, " R9 stays stopped"}, {28'd0, s[15:12]}, 32'd3);
        wr(2'd0, 32'h0);
        repeat (3) @(negedge clk);
        rd(2'd3, s);
        check(s[19:0] == 20'd0, {tag, " R1 disable clears"}, {12'd0, s[19:0]}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] s;
        int off;
        int b0;
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 2048; i++) mem[i] = $urandom;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(2'd3, v);
        check(v[19:0] == 20'd0, "R1 status after reset", v, 32'd0);
        rd(2'd0, v);
        check(v == 32'd0, "R1 control after reset", v, 32'd0);
        check(!tx_valid && !mem_req && !irq, "R1 outputs quiet", {29'd0, tx_valid, mem_req, irq}, 32'd0);

        // R2 register field masks
        wr(2'd1, 32'h0000_5ABC);
        rd(2'd1, v);
        check(v == 32'h0000_5000, "R2 base alignment", v, 32'h5000);
        wr(2'd2, 32'hFFFF_F12F);
        rd(2'd2, v);
        check(v == 32'h0000_0128, "R2 post mask", v, 32'h128);
        wr(2'd0, 32'hFFFF_FFE8);
        rd(2'd0, v);
        check(v == 32'h0000_0000, "R2 control spare bits", v, 32'd0);
        wr(2'd1, 32'h0);
        wr(2'd2, 32'h0);

        // R3 R4 R8: unaligned buffers, frame spanning two descriptors, core bits set
        put_desc(32'h00, F_SOF | F_IOC | 32'd5, 32'h1003);
        put_desc(32'h08, F_EOF | 32'h0A50_0000 | 32'd6, 32'h1101);
        put_desc(32'h10, F_SOF | F_EOF | F_IOC | 32'h0FF0_0000 | 32'd1, 32'h1200);
        expect_desc(F_SOF | F_IOC | 32'd5, 32'h1003);
        expect_desc(F_EOF | 32'd6, 32'h1101);
        expect_desc(F_SOF | F_EOF | F_IOC | 32'd1, 32'h1200);
        wr(2'd2, 32'h18);
        wr(2'd0, 32'h1);
        wait_idle(12'h018, "directed");
        rd(2'd3, v);
        check(v[31:20] == 12'h010, "R4 active offset", {20'd0, v[31:20]}, 32'h10);

        // R7 wrap on end-of-table, R6 resume on new post
        put_desc(32'h18, F_SOF | F_EOF | F_EOT | 32'd4, 32'h1300);
        expect_desc(F_SOF | F_EOF | F_EOT | 32'd4, 32'h1300);
        wr(2'd2, 32'h0);
        wait_idle(12'h000, "wrap");

        // R9 protocol errors
        wr(2'd2, 32'h8);
        wr(2'd0, 32'h0);
        stop_case(F_EOF | 32'd3, 32'h1000, 4'd1, "R9 sof missing");
        stop_case(F_SOF | F_EOF | 32'd0, 32'h1000, 4'd1, "R9 zero count");

        // R10 bus errors
        wr(2'd1, 32'h3000);
        stop_case(F_SOF | F_EOF | 32'd4, 32'h1000, 4'd4, "R10 descriptor read");
        wr(2'd1, 32'h0);
        stop_case(F_SOF | F_EOF | 32'd4, 32'h4000, 4'd3, "R10 buffer read");

        // R11 suspend
        put_desc(32'h00, F_SOF | 32'd3, 32'h1010);
        put_desc(32'h08, F_EOF | F_IOC | 32'd3, 32'h1020);
        put_desc(32'h10, F_SOF | F_EOF | 32'd2, 32'h1030);
        expect_desc(F_SOF | 32'd3, 32'h1010);
        wr(2'd2, 32'h8);
        wr(2'd0, 32'h1);
        wait_idle(12'h008, "suspend setup");
        wr(2'd0, 32'h3);
        rd(2'd3, v);
        check(v[15:12] == 4'd4, "R11 suspend pending", {28'd0, v[15:12]}, 32'd4);
        expect_desc(F_EOF | F_IOC | 32'd3, 32'h1020);
        wr(2'd2, 32'h10);
        wait_idle(12'h010, "R11 frame completes");
        wr(2'd2, 32'h18);
        b0 = bytes_seen;
        repeat (60) @(negedge clk);
        rd(2'd3, v);
        check(bytes_seen == b0, "R11 no bytes while held", bytes_seen, b0);
        check(v[15:0] == 16'h2010, "R11 held idle", {16'd0, v[15:0]}, 32'h2010);
        expect_desc(F_SOF | F_EOF | 32'd2, 32'h1030);
        wr(2'd0, 32'h1);
        wait_idle(12'h018, "R11 resume");

        // R12 flush mid-descriptor
        put_desc(32'h18, F_SOF | F_EOF | 32'd40, 32'h1400);
        rdy_pct = 0;
        wr(2'd2, 32'h20);
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            #3;
            if (tx_valid) break;
        end
        check(tx_valid, "R12 stalled byte offered", {31'd0, tx_valid}, 32'd1);
        wr(2'd0, 32'h11);
        repeat (3) @(negedge clk);
        #3;
        check(!tx_valid, "R12 flush drops tx_valid", {31'd0, tx_valid}, 32'd0);
        rd(2'd3, v);
        check(v[19:0] == 20'd0, "R12 flush status", {12'd0, v[19:0]}, 32'd0);
        wr(2'd2, 32'h0);
        wr(2'd0, 32'h1);
        rdy_pct = 70;
        b0 = bytes_seen;
        repeat (30) @(negedge clk);
        rd(2'd3, v);
        check(v[15:0] == 16'h2000 && bytes_seen == b0, "R12 clean restart", {16'd0, v[15:0]}, 32'h2000);

        // R13 loopback flag
        wr(2'd0, 32'h5);
        #3;
        check(loopback == 1'b1, "R13 loopback on", {31'd0, loopback}, 32'd1);
        wr(2'd0, 32'h1);
        #3;
        check(loopback == 1'b0, "R13 loopback off", {31'd0, loopback}, 32'd0);

        // random batches: R4 R5 R6 R7 R8 R14
        off = 0;
        for (int r = 0; r < 8; r++) begin
            int k;
            bit open;
            int nxt;
            rdy_pct = 30 + $urandom_range(70);
            lat_max = $urandom_range(3);
            k = 2 + $urandom_range(8);
            open = 0;
            for (int j = 0; j < k; j++) begin
                logic [31:0] c;
                logic [31:0] a;
                int n;
                n = 1 + $urandom_range(23);
                a = 32'h1000 + $urandom_range(4096 - 32);
                c = 32'(n);
                if (!open) c |= F_SOF;
                if (j == k - 1 || $urandom_range(1) == 1) begin c |= F_EOF; open = 0; end
                else open = 1;
                if ($urandom_range(1) == 1) c |= F_IOC;
                if (j == k - 1 && (r % 2 == 1)) c |= F_EOT;
                put_desc(off + 8 * j, c, a);
                expect_desc(c, a);
            end
            nxt = (r % 2 == 1) ? 0 : off + 8 * k;
            wr(2'd2, 32'(nxt));
            wait_idle(12'(nxt), "random");
            off = nxt;
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule